// File: doc/BRIEF.md
# TMDS Channel Encoder

This block turns one 8-bit colour component into one 10-bit TMDS symbol on every pixel clock. In active video it encodes the byte in two steps. First it forms a 9-bit word that has few transitions between bits. Then it optionally inverts that word to keep the line DC balanced, using a signed disparity tally that it carries from one symbol to the next. During blanking it sends one of four fixed control tokens, selected by two control bits. The symbol is registered, so it appears one clock after its inputs are sampled.

A display transmitter uses three instances, one each for blue, green and red. The blue instance carries horizontal sync on control bit 0 and vertical sync on control bit 1. Red and green tie their control bits to 00. A downstream serializer shifts each symbol out, least significant bit first.

Top module: `tmds_lane_encoder`

## Requirements
- R1: While `rst_in` is high, `sym_out` is 0 at the next clock edge and the disparity tally is cleared.
- R2: Inputs sampled at a rising edge determine `sym_out` from that edge on, one cycle of latency. Between edges the output holds.
- R3: With `vid_en_in` low, `sym_out` takes a fixed token selected by `ctl_in` (bit 0 = hsync, bit 1 = vsync): 00 gives 10'b1101010100, 01 gives 10'b0010101011, 10 gives 10'b0101010100, 11 gives 10'b1010101011.
- R4: Sending a control token clears the tally, so the next data symbol is encoded as it would be after reset.
- R5: Stage one chains with XNOR when the byte has more than four ones, or exactly four ones with bit 0 clear. Otherwise it chains with XOR. Symbol bit 8 is 1 for XOR and 0 for XNOR. Bit 0 of the chain equals data bit 0.
- R6: Symbol bit 9 set means bits 7:0 hold the inverted chain word. Every data symbol decodes back to its input byte.
- R7: When the tally is zero, or the chain's low byte has exactly four ones, bit 9 is the inverse of bit 8. The low byte is inverted exactly when bit 8 is 0.
- R8: Otherwise the low byte is inverted, with bit 9 set, when the tally and the low byte's imbalance have the same sign. The tally always equals the sum of (ones minus zeros) of the 10-bit symbols sent since the last reset or control token. It stays even and within ±10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Pixel clock |
| rst_in | input | 1 | Synchronous reset, active high |
| pix_in | input | 8 | Colour component byte |
| ctl_in | input | 2 | Control bits used during blanking (bit 0 hsync, bit 1 vsync on blue) |
| vid_en_in | input | 1 | High in active video, low in blanking |
| sym_out | output | 10 | Registered TMDS symbol |

## Verification
The assertions assume `rst_in` is asserted at the first clock edge. They also assume `vid_en_in`, `ctl_in` and `pix_in` are settled before each rising edge. The bench therefore holds reset over the first edges and changes every input only on falling edges. The decode assertion relies on the data byte seen at the previous edge, and the bench keeps the inputs stable across each edge. Control bits are only meaningful with `vid_en_in` low, and the bench changes them freely during data as well, to confirm that they are then ignored.

// File: rtl/tmds_lane_encoder.sv
module tmds_lane_encoder #(
  parameter int TALLY_W = 6
) (
  input  logic        clk_in,
  input  logic        rst_in,
  input  logic [7:0]  pix_in,
  input  logic [1:0]  ctl_in,
  input  logic        vid_en_in,
  output logic [9:0]  sym_out
);
  localparam logic signed [TALLY_W-1:0] TWO   = TALLY_W'(2);
  localparam logic signed [TALLY_W-1:0] EIGHT = TALLY_W'(8);
  localparam logic signed [TALLY_W-1:0] LIMIT = TALLY_W'(10);

  logic [3:0] n_pix, n_q;
  logic       use_xnor;
  logic [8:0] q;
  logic signed [TALLY_W-1:0] tally, tally_nx, imb, corr, corr_n;
  logic [9:0] sym_nx;

  always_comb begin
    n_pix = '0;
    for (int i = 0; i < 8; i++) n_pix = n_pix + 4'(pix_in[i]);
  end

  assign use_xnor = (n_pix > 4'd4) || (n_pix == 4'd4 && !pix_in[0]);

  always_comb begin
    logic prev;
    prev = pix_in[0];
    q[0] = prev;
    for (int i = 1; i < 8; i++) begin
      prev = use_xnor ? ~(prev ^ pix_in[i]) : (prev ^ pix_in[i]);
      q[i] = prev;
    end
    q[8] = ~use_xnor;
  end

  always_comb begin
    n_q = '0;
    for (int i = 0; i < 8; i++) n_q = n_q + 4'(q[i]);
  end

  assign imb    = $signed(TALLY_W'({n_q, 1'b0})) - EIGHT;
  assign corr   = q[8] ? TWO : '0;
  assign corr_n = q[8] ? '0 : TWO;

  always_comb begin
    if (!vid_en_in) begin
      tally_nx = '0;
      case (ctl_in)
        2'b00:   sym_nx = 10'b1101010100;
        2'b01:   sym_nx = 10'b0010101011;
        2'b10:   sym_nx = 10'b0101010100;
        default: sym_nx = 10'b1010101011;
      endcase
    end else if (tally == '0 || n_q == 4'd4) begin
      sym_nx   = {~q[8], q[8], q[8] ? q[7:0] : ~q[7:0]};
      tally_nx = q[8] ? tally + imb : tally - imb;
    end else if ((!tally[TALLY_W-1] && n_q > 4'd4) || (tally[TALLY_W-1] && n_q < 4'd4)) begin
      sym_nx   = {1'b1, q[8], ~q[7:0]};
      tally_nx = tally + corr - imb;
    end else begin
      sym_nx   = {1'b0, q[8], q[7:0]};
      tally_nx = tally - corr_n + imb;
    end
  end

  always_ff @(posedge clk_in) begin
    if (rst_in) begin
      sym_out <= '0;
      tally   <= '0;
    end else begin
      sym_out <= sym_nx;
      tally   <= tally_nx;
    end
  end

  function automatic logic [7:0] unpack(input logic [9:0] s);
    logic [7:0] w;
    logic [7:0] d;
    w = s[9] ? ~s[7:0] : s[7:0];
    d[0] = w[0];
    for (int i = 1; i < 8; i++) d[i] = s[8] ? (w[i] ^ w[i-1]) : ~(w[i] ^ w[i-1]);
    return d;
  endfunction

  // R1
  reset_clear_chk: assert property (@(posedge clk_in)
    rst_in |=> (sym_out == '0 && tally == '0));

  // R6
  lossless_chk: assert property (@(posedge clk_in) disable iff (rst_in)
    vid_en_in |=> unpack(sym_out) == $past(pix_in));

  // R4
  blank_tally_chk: assert property (@(posedge clk_in) disable iff (rst_in)
    !vid_en_in |=> tally == '0);

  // R7
  neutral_flag_chk: assert property (@(posedge clk_in) disable iff (rst_in)
    (vid_en_in && tally == '0) |=> sym_out[9] != sym_out[8]);

  // R8
  tally_bound_chk: assert property (@(posedge clk_in) disable iff (rst_in)
    (tally <= LIMIT) && (tally >= -LIMIT) && !tally[0]);
endmodule

// File: tb/test_tmds_lane_encoder.sv
module test_tmds_lane_encoder;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] pix;
  logic [1:0] ctl;
  logic       ven;
  logic [9:0] sym;
  int total = 0;
  int bad = 0;
  int disp = 0;

  always #2 clk = ~clk;

  tmds_lane_encoder i_tmds_lane_encoder (
    .clk_in(clk), .rst_in(rst), .pix_in(pix), .ctl_in(ctl),
    .vid_en_in(ven), .sym_out(sym)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] decode(input logic [9:0] s);
    logic [7:0] w;
    logic [7:0] d;
    w = s[9] ? ~s[7:0] : s[7:0];
    d[0] = w[0];
    for (int i = 1; i < 8; i++) d[i] = s[8] ? (w[i] ^ w[i-1]) : ~(w[i] ^ w[i-1]);
    return d;
  endfunction

  function automatic int weight(input logic [9:0] s);
    int n;
    n = 0;
    for (int i = 0; i < 10; i++) n += s[i];
    return 2 * n - 10;
  endfunction

  task automatic send(input logic v, input logic [1:0] c, input logic [7:0] d);
    @(negedge clk);
    ven = v; ctl = c; pix = d;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; ven = 1'b1; pix = 8'hA5;
    @(posedge clk); #1;
    chk("R1 reset output", 32'(sym), 32'h000);
    @(negedge clk);
    rst = 1'b0;
    send(1'b1, 2'b00, 8'h00);
    chk("R1 tally cleared by reset", 32'(sym), 32'h100);
  endtask

  task automatic t_latency;
    send(1'b0, 2'b00, 8'h00);
    @(negedge clk);
    ven = 1'b1; pix = 8'h01;
    #1;
    chk("R2 holds before edge", 32'(sym), 32'h354);
    @(posedge clk); #1;
    chk("R2 updates after edge", 32'(sym), 32'h1FF);
  endtask

  task automatic t_control;
    send(1'b0, 2'b00, 8'h3C);
    chk("R3 token 00", 32'(sym), 32'h354);
    send(1'b0, 2'b01, 8'h3C);
    chk("R3 token 01 hsync", 32'(sym), 32'h0AB);
    send(1'b0, 2'b10, 8'h3C);
    chk("R3 token 10 vsync", 32'(sym), 32'h154);
    send(1'b0, 2'b11, 8'h3C);
    chk("R3 token 11", 32'(sym), 32'h2AB);
  endtask

  task automatic t_select;
    send(1'b0, 2'b00, 8'h00);
    send(1'b1, 2'b11, 8'h0F);
    chk("R5 four ones bit0 set uses XOR", 32'(sym), 32'h105);
    send(1'b0, 2'b00, 8'h00);
    send(1'b1, 2'b10, 8'h1E);
    chk("R5 four ones bit0 clear uses XNOR", 32'(sym), 32'h25F);
    send(1'b0, 2'b00, 8'h00);
    send(1'b1, 2'b01, 8'hFF);
    chk("R5 R7 all ones XNOR inverted", 32'(sym), 32'h200);
  endtask

  task automatic t_tally;
    send(1'b0, 2'b00, 8'h00);
    send(1'b1, 2'b00, 8'h00);
    chk("R7 zero tally", 32'(sym), 32'h100);
    send(1'b1, 2'b00, 8'h00);
    chk("R8 same sign inverts", 32'(sym), 32'h3FF);
    send(1'b1, 2'b00, 8'h00);
    chk("R8 opposite sign keeps", 32'(sym), 32'h100);
    send(1'b0, 2'b00, 8'h00);
    send(1'b1, 2'b00, 8'h01);
    chk("R4 R7 tally cleared by token", 32'(sym), 32'h1FF);
    send(1'b1, 2'b00, 8'h01);
    chk("R8 positive tally inverts", 32'(sym), 32'h300);
    send(1'b1, 2'b00, 8'h01);
    chk("R8 tally still positive", 32'(sym), 32'h300);
    send(1'b1, 2'b00, 8'h01);
    chk("R8 negative tally keeps", 32'(sym), 32'h1FF);
  endtask

  task automatic t_stream;
    logic [15:0] lfsr;
    int errs;
    lfsr = 16'hACE1;
    errs = 0;
    send(1'b0, 2'b00, 8'h00);
    disp = 0;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n % 97 == 96) begin
        send(1'b0, lfsr[1:0], lfsr[9:2]);
        disp = 0;
      end else begin
        send(1'b1, lfsr[1:0], lfsr[9:2]);
        disp += weight(sym);
        if (decode(sym) !== lfsr[9:2]) begin
          errs++;
          if (errs < 4) chk("R6 decode", 32'(decode(sym)), 32'(lfsr[9:2]));
        end
        if (disp > 10 || disp < -10) begin
          errs++;
          if (errs < 4) chk("R8 disparity bound", 32'(disp), 32'd10);
        end
      end
    end
    chk("R6 R8 stream errors", 32'(errs), 32'd0);
  endtask

  initial begin
    rst = 1'b1; ven = 1'b0; ctl = 2'b00; pix = 8'h00;
    repeat (3) @(posedge clk);
    t_reset();
    t_latency();
    t_control();
    t_select();
    t_tally();
    t_stream();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule